// File: doc/BRIEF.md
# PC Card Host Cycle Sequencer

This block runs the host side of 16-bit PC Card accesses to common memory and to I/O space. A local master hands it one request at a time: address, write data, a 16-bit/byte flag, a direction flag, a memory/I/O flag, a register-space flag and a count of extra wait states. The block then drives the card's enable lines, register-space line, address, data bus enable and exactly one of the four strobes. It answers with read data and a single-cycle completion pulse. The card's WAIT and IOIS16 lines pass through a two-flop synchronizer before the block acts on them.

Every interval is a whole number of clocks of a roughly 33 MHz bus clock. An access is a setup phase, a strobe phase and a hold phase. Memory and I/O accesses have setup lengths of their own. The strobe length is a base value plus the programmed wait states, and it is stretched for as long as the card holds WAIT low. The block accepts no new request until the hold phase has finished.

Top module: `pcc_cycle_seq`

## Requirements
- R1: After reset and while idle, all strobes, both card enables and the register-space line are high (inactive), the data bus enable is low, `req_ready` is high and `rsp_done` is low.
- R2: The first card enable (`card_ce1_n`) is low for the last 2 or more clocks before a strobe falls. It stays low for exactly 4 clocks after the strobe rises.
- R3: Memory accesses have 3 setup clocks and I/O accesses have 5 setup clocks between acceptance and the strobe falling. Address and register-space line stay stable while the strobe is low.
- R4: Exactly one strobe is driven per access: `card_oe_n` for a memory read, `card_we_n` for a memory write, `card_iord_n` for an I/O read and `card_iowr_n` for an I/O write.
- R5: For writes, `card_data_oe` is high from the clock after acceptance until the end of the hold phase, with `card_wdata` equal to the request data. For reads it stays low.
- R6: With WAIT high, the strobe is low for 7 plus `req_wait_cnt` clocks in a memory access and 6 plus `req_wait_cnt` clocks in an I/O access.
- R7: The strobe stays low while the synchronized WAIT is low. If WAIT rises during strobe clock k (counted from 1), the strobe lasts max(base length, k+2) clocks.
- R8: `card_reg_n` is low throughout every I/O access and throughout memory accesses that have `req_attr` set. Otherwise it stays high.
- R9: In memory accesses, `card_ce2_n` goes low together with `card_ce1_n` only for 16-bit requests. In I/O accesses neither enable goes low before the third clock edge after acceptance. At that edge the synchronized IOIS16 is sampled, and `card_ce2_n` goes low only if the request is 16-bit and IOIS16 was low (a 16-bit card port).
- R10: Read data is taken from `card_rdata` at the clock edge where the strobe rises. When only `card_ce1_n` was low, the upper byte of `rsp_rdata` is zero.
- R11: `rsp_done` is a one-clock pulse that comes setup + strobe + 4 clocks after acceptance. `req_ready` is low from acceptance until that pulse, and requests offered in between are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_addr | input | AW | Card address |
| req_wdata | input | DW | Write data |
| req_wide | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = common memory |
| req_attr | input | 1 | Register-space select for memory accesses |
| req_wait_cnt | input | WS_W | Extra wait states added to the strobe |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DW | Read data of the last read |
| card_addr | output | AW | Address to the card |
| card_wdata | output | DW | Data driven toward the card |
| card_data_oe | output | 1 | Enable for the host data drivers |
| card_rdata | input | DW | Data returned by the card |
| card_ce1_n | output | 1 | Low byte enable, active low |
| card_ce2_n | output | 1 | High byte enable, active low |
| card_reg_n | output | 1 | Register-space / I/O select, active low |
| card_oe_n | output | 1 | Memory read strobe |
| card_we_n | output | 1 | Memory write strobe |
| card_iord_n | output | 1 | I/O read strobe |
| card_iowr_n | output | 1 | I/O write strobe |
| card_wait_n | input | 1 | Card wait request, active low |
| card_iois16_n | input | 1 | Card 16-bit I/O port indication, active low |

## Verification
Two functions can decide the end of the strobe on the same clock edge: the wait-state counter reaching its last clock, and the synchronized WAIT returning high. The bench provokes this by releasing WAIT during strobe clock 5 of a 7-clock memory access, so the release and the count expiry meet on one edge. It expects exactly 7 strobe clocks. Releasing WAIT one clock later must give 8 clocks, and a late release must give release+2. An I/O access with a late release covers the same stretch against the shorter I/O base length.

// File: rtl/pcc_seq_pkg.sv
package pcc_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } pcc_phase_e;

   function automatic int pcc_max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int pcc_max4(input int a, input int b, input int c, input int d);
      return pcc_max2(pcc_max2(a, b), pcc_max2(c, d));
   endfunction

endpackage

// File: rtl/pcc_sync_bus.sv
module pcc_sync_bus #(
   parameter int   W       = 2,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pcc_sync_bus: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("pcc_sync_bus: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
         end else begin
            chain <= {chain[STAGES-2:0], din[b]};
         end
      end
      assign dout[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/pcc_phase_ctrl.sv
module pcc_phase_ctrl
   import pcc_seq_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] su_len,
   input  logic [CNT_W-1:0] strobe_len,
   input  logic [CNT_W-1:0] hold_len,
   input  logic             wait_ok,
   output pcc_phase_e       phase,
   output logic [CNT_W-1:0] cnt,
   output logic             strobe_end,
   output logic             hold_end
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("pcc_phase_ctrl: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cur_len;
   logic             last;

   always_comb begin
      unique case (phase)
         PH_SETUP:  cur_len = su_len;
         PH_STROBE: cur_len = strobe_len;
         PH_HOLD:   cur_len = hold_len;
         default:   cur_len = '0;
      endcase
   end

   assign last       = (cnt == cur_len - CNT_W'(1));
   assign strobe_end = (phase == PH_STROBE) && last && wait_ok;
   assign hold_end   = (phase == PH_HOLD) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               cnt <= '0;
               if (start) phase <= PH_SETUP;
            end
            PH_SETUP: begin
               if (last) begin
                  phase <= PH_STROBE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            PH_STROBE: begin
               if (last) begin
                  if (wait_ok) begin
                     phase <= PH_HOLD;
                     cnt   <= '0;
                  end
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            PH_HOLD: begin
               if (last) begin
                  phase <= PH_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: begin
               phase <= PH_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   // R6: the phase counter never passes the length of the current phase
   p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |-> (cnt < cur_len));

   // R11: the hold phase always returns to idle on the next edge
   p_hold_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hold_end |=> (phase == PH_IDLE));

endmodule

// File: rtl/pcc_pin_decode.sv
module pcc_pin_decode
   import pcc_seq_pkg::*;
#(
   parameter int CNT_W     = 5,
   parameter int IOIS_PICK = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pcc_phase_e       phase,
   input  logic [CNT_W-1:0] cnt,
   input  logic             io,
   input  logic             write,
   input  logic             attr,
   input  logic             wide,
   output logic             ce1_n,
   output logic             ce2_n,
   output logic             reg_n,
   output logic             oe_n,
   output logic             we_n,
   output logic             iord_n,
   output logic             iowr_n,
   output logic             data_oe
);

   logic busy;
   logic ce_on;
   logic strobe_on;

   assign busy      = (phase != PH_IDLE);
   assign strobe_on = (phase == PH_STROBE);

   always_comb begin
      if (!busy) begin
         ce_on = 1'b0;
      end else if (io && (phase == PH_SETUP)) begin
         ce_on = (cnt >= CNT_W'(IOIS_PICK));
      end else begin
         ce_on = 1'b1;
      end
   end

   assign ce1_n   = !ce_on;
   assign ce2_n   = !(ce_on && wide);
   assign reg_n   = !(busy && (io || attr));
   assign oe_n    = !(strobe_on && !io && !write);
   assign we_n    = !(strobe_on && !io && write);
   assign iord_n  = !(strobe_on && io && !write);
   assign iowr_n  = !(strobe_on && io && write);
   assign data_oe = busy && write;

   // R5: a write strobe is never low without the data drivers enabled
   p_wdata_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || !iowr_n) |-> data_oe);

   // R9: the high byte enable is never low without the low byte enable
   p_ce2_with_ce1_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ce2_n |-> !ce1_n);

endmodule

// File: rtl/pcc_cycle_seq.sv
module pcc_cycle_seq
   import pcc_seq_pkg::*;
#(
   parameter int AW             = 26,
   parameter int DW             = 16,
   parameter int WS_W           = 4,
   parameter int SYNC_STAGES    = 2,
   parameter int CE_SU          = 2,
   parameter int CE_HOLD        = 4,
   parameter int MEM_REG_SU     = 3,
   parameter int IO_REG_SU      = 2,
   parameter int ADDR_SU_BASE   = 1,
   parameter int ADDR_HOLD_BASE = 1,
   parameter int MEM_PULSE      = 7,
   parameter int IO_PULSE       = 6,
   parameter int MEM_WD_SU      = 2,
   parameter int MEM_WD_SPAN    = 8,
   parameter int IO_WD_SU       = 3,
   parameter int IO_WD_HOLD     = 3,
   parameter int IOIS_PICK      = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [AW-1:0]   req_addr,
   input  logic [DW-1:0]   req_wdata,
   input  logic            req_wide,
   input  logic            req_write,
   input  logic            req_io,
   input  logic            req_attr,
   input  logic [WS_W-1:0] req_wait_cnt,
   output logic            rsp_done,
   output logic [DW-1:0]   rsp_rdata,
   output logic [AW-1:0]   card_addr,
   output logic [DW-1:0]   card_wdata,
   output logic            card_data_oe,
   input  logic [DW-1:0]   card_rdata,
   output logic            card_ce1_n,
   output logic            card_ce2_n,
   output logic            card_reg_n,
   output logic            card_oe_n,
   output logic            card_we_n,
   output logic            card_iord_n,
   output logic            card_iowr_n,
   input  logic            card_wait_n,
   input  logic            card_iois16_n
);

   // ---- derived interval lengths, in clocks ----
   localparam int SU_MEM   = pcc_max4(CE_SU, MEM_REG_SU, ADDR_SU_BASE + 2, MEM_WD_SU);
   localparam int SU_IO    = pcc_max4(IOIS_PICK + CE_SU, IO_REG_SU, ADDR_SU_BASE + 2, IO_WD_SU);
   localparam int WD_TAIL  = (MEM_WD_SPAN > MEM_PULSE) ? (MEM_WD_SPAN - MEM_PULSE) : 0;
   localparam int HOLD_LEN = pcc_max4(CE_HOLD, ADDR_HOLD_BASE + 1, IO_WD_HOLD, WD_TAIL);
   localparam int WS_MAX   = (1 << WS_W) - 1;
   localparam int MAX_LEN  = pcc_max4(SU_MEM, SU_IO, HOLD_LEN,
                                      pcc_max2(MEM_PULSE, IO_PULSE) + WS_MAX);
   localparam int CNT_W    = $clog2(MAX_LEN + 1) + 1;
   localparam int LANE_HI  = DW - 8;

   // ---- elaboration checks ----
   if (DW < 16 || (DW % 8) != 0) begin : g_bad_dw
      $error("pcc_cycle_seq: DW must be a multiple of 8 and at least 16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pcc_cycle_seq: SYNC_STAGES must be at least 2");
   end
   if (IOIS_PICK < SYNC_STAGES + 1) begin : g_bad_pick
      $error("pcc_cycle_seq: IOIS_PICK must leave room for the synchronizer");
   end
   if (MEM_PULSE < SYNC_STAGES + 1 || IO_PULSE < SYNC_STAGES + 1) begin : g_bad_pulse
      $error("pcc_cycle_seq: strobe base must exceed synchronizer latency");
   end
   if (CE_SU < 1 || CE_HOLD < 1 || WS_W < 1) begin : g_bad_misc
      $error("pcc_cycle_seq: CE_SU, CE_HOLD and WS_W must be positive");
   end

   // ---- latched request ----
   logic [AW-1:0]    addr_q;
   logic [DW-1:0]    wdata_q;
   logic             wide_q;
   logic             write_q;
   logic             io_q;
   logic             attr_q;
   logic [CNT_W-1:0] su_len_q;
   logic [CNT_W-1:0] pulse_len_q;

   // ---- sequencing ----
   pcc_phase_e       phase;
   logic [CNT_W-1:0] cnt;
   logic             strobe_end;
   logic             hold_end;
   logic             accept;
   logic             wait_s_n;
   logic             iois_s_n;
   logic             pick_now;
   logic [DW-1:0]    rd_pick;
   logic             strobe_l;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid && req_ready;
   assign pick_now  = io_q && (phase == PH_SETUP) && (cnt == CNT_W'(IOIS_PICK - 1));

   pcc_sync_bus #(
      .W       (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({card_wait_n, card_iois16_n}),
      .dout ({wait_s_n, iois_s_n})
   );

   pcc_phase_ctrl #(
      .CNT_W (CNT_W)
   ) i_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .su_len    (su_len_q),
      .strobe_len(pulse_len_q),
      .hold_len  (CNT_W'(HOLD_LEN)),
      .wait_ok   (wait_s_n),
      .phase     (phase),
      .cnt       (cnt),
      .strobe_end(strobe_end),
      .hold_end  (hold_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q      <= '0;
         wdata_q     <= '0;
         wide_q      <= 1'b0;
         write_q     <= 1'b0;
         io_q        <= 1'b0;
         attr_q      <= 1'b0;
         su_len_q    <= CNT_W'(SU_MEM);
         pulse_len_q <= CNT_W'(MEM_PULSE);
      end else if (accept) begin
         addr_q      <= req_addr;
         wdata_q     <= req_wdata;
         wide_q      <= req_wide;
         write_q     <= req_write;
         io_q        <= req_io;
         attr_q      <= req_attr;
         su_len_q    <= req_io ? CNT_W'(SU_IO) : CNT_W'(SU_MEM);
         pulse_len_q <= (req_io ? CNT_W'(IO_PULSE) : CNT_W'(MEM_PULSE))
                        + CNT_W'(req_wait_cnt);
      end else if (pick_now) begin
         wide_q <= wide_q && !iois_s_n;
      end
   end

   // read lane selection: only the low lane is kept on a byte transfer
   for (genvar l = 0; l < DW / 8; l++) begin : g_lane
      if (l == 0) begin : g_low
         assign rd_pick[7:0] = card_rdata[7:0];
      end else begin : g_up
         assign rd_pick[l*8 +: 8] = wide_q ? card_rdata[l*8 +: 8] : 8'h00;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_rdata <= '0;
         rsp_done  <= 1'b0;
      end else begin
         rsp_done <= hold_end;
         if (strobe_end && !write_q) begin
            rsp_rdata <= rd_pick;
         end
      end
   end

   pcc_pin_decode #(
      .CNT_W    (CNT_W),
      .IOIS_PICK(IOIS_PICK)
   ) i_decode (
      .clk    (clk),
      .rst_n  (rst_n),
      .phase  (phase),
      .cnt    (cnt),
      .io     (io_q),
      .write  (write_q),
      .attr   (attr_q),
      .wide   (wide_q),
      .ce1_n  (card_ce1_n),
      .ce2_n  (card_ce2_n),
      .reg_n  (card_reg_n),
      .oe_n   (card_oe_n),
      .we_n   (card_we_n),
      .iord_n (card_iord_n),
      .iowr_n (card_iowr_n),
      .data_oe(card_data_oe)
   );

   assign card_addr  = addr_q;
   assign card_wdata = wdata_q;
   assign strobe_l   = !card_oe_n || !card_we_n || !card_iord_n || !card_iowr_n;

   // ---- protocol checks ----
   // R4: at most one strobe is low at any time
   p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({!card_oe_n, !card_we_n, !card_iord_n, !card_iowr_n}) <= 1);

   // R2: card enable low on the two clocks before the strobe falls
   p_ce_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_l) |-> (!$past(card_ce1_n) && !$past(card_ce1_n, 2)));

   // R2: card enable still low right after the strobe rises
   p_ce_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe_l) |-> !card_ce1_n);

   // R7: a low synchronized WAIT keeps the strobe low on the next clock
   p_wait_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_l && !wait_s_n) |=> strobe_l);

   // R3: address and register-space line do not move under the strobe
   p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_l && $past(strobe_l)) |-> ($stable(card_addr) && $stable(card_reg_n)));

   // R11: completion is a single-clock pulse
   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R11: completion is only signalled when a new request can be taken
   p_done_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready);

   // R11: ready only drops because a request was offered
   p_ready_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_ready) |-> $past(req_valid));

endmodule

// File: tb/test_pcc_cycle_seq.sv
module test_pcc_cycle_seq;

   localparam int AW = 26;
   localparam int DW = 16;
   localparam int WS_W = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [AW-1:0]   req_addr = '0;
   logic [DW-1:0]   req_wdata = '0;
   logic            req_wide = 1'b0;
   logic            req_write = 1'b0;
   logic            req_io = 1'b0;
   logic            req_attr = 1'b0;
   logic [WS_W-1:0] req_wait_cnt = '0;
   logic            rsp_done;
   logic [DW-1:0]   rsp_rdata;
   logic [AW-1:0]   card_addr;
   logic [DW-1:0]   card_wdata;
   logic            card_data_oe;
   logic [DW-1:0]   card_rdata = '0;
   logic            card_ce1_n, card_ce2_n, card_reg_n;
   logic            card_oe_n, card_we_n, card_iord_n, card_iowr_n;
   logic            card_wait_n = 1'b1;
   logic            card_iois16_n = 1'b1;

   always #10 clk = ~clk;

   pcc_cycle_seq i_pcc_cycle_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .req_wide     (req_wide),
      .req_write    (req_write),
      .req_io       (req_io),
      .req_attr     (req_attr),
      .req_wait_cnt (req_wait_cnt),
      .rsp_done     (rsp_done),
      .rsp_rdata    (rsp_rdata),
      .card_addr    (card_addr),
      .card_wdata   (card_wdata),
      .card_data_oe (card_data_oe),
      .card_rdata   (card_rdata),
      .card_ce1_n   (card_ce1_n),
      .card_ce2_n   (card_ce2_n),
      .card_reg_n   (card_reg_n),
      .card_oe_n    (card_oe_n),
      .card_we_n    (card_we_n),
      .card_iord_n  (card_iord_n),
      .card_iowr_n  (card_iowr_n),
      .card_wait_n  (card_wait_n),
      .card_iois16_n(card_iois16_n)
   );

   typedef struct {
      int            lat;
      int            slen;
      int            pin;
      int            ce_pre;
      int            doe;
      bit            ce2_low;
      bit            reg_low;
      bit            is_read;
      logic [DW-1:0] rd;
      logic [DW-1:0] wd;
      logic [AW-1:0] addr;
   } exp_t;

   exp_t exp_q[$];

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // monitor state
   bit            busy_tb = 1'b0;
   int            m_lat, m_slen, m_pin, m_pre, m_post, m_doe, m_wait_rel;
   bit            m_seen, m_ce2, m_reg, m_addr_ok, m_wd_ok;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: sample pins away from the active edge, compare on completion
   always @(negedge clk) begin
      if (busy_tb) begin
         if (!card_oe_n || !card_we_n || !card_iord_n || !card_iowr_n) begin
            m_slen++;
            m_seen = 1'b1;
            m_pin  = (!card_oe_n ? 1 : 0) + (!card_we_n ? 2 : 0)
                   + (!card_iord_n ? 3 : 0) + (!card_iowr_n ? 4 : 0);
            m_ce2  = !card_ce2_n;
            m_reg  = !card_reg_n;
            if (m_wait_rel > 0 && m_slen == m_wait_rel) card_wait_n = 1'b1;
         end else if (!card_ce1_n) begin
            if (m_seen) m_post++;
            else        m_pre++;
         end
         if (card_data_oe) m_doe++;
         if (!card_ce1_n && exp_q.size() > 0) begin
            if (card_addr != exp_q[0].addr) m_addr_ok = 1'b0;
            if (card_data_oe && card_wdata != exp_q[0].wd) m_wd_ok = 1'b0;
         end
         if (rsp_done) begin
            exp_t e;
            e = exp_q.pop_front();
            check("R11", "latency", m_lat, e.lat);
            check("R6/R7", "strobe clocks", m_slen, e.slen);
            check("R4", "strobe id", m_pin, e.pin);
            check("R2/R3/R9", "enable clocks before strobe", m_pre, e.ce_pre);
            check("R2", "enable clocks after strobe", m_post, 4);
            check("R9", "high enable", int'(m_ce2), int'(e.ce2_low));
            check("R8", "register line", int'(m_reg), int'(e.reg_low));
            check("R5", "data enable clocks", m_doe, e.doe);
            check("R3", "address held", int'(m_addr_ok), 1);
            check("R5", "write data", int'(m_wd_ok), 1);
            check("R11", "ready at done", int'(req_ready), 1);
            if (e.is_read) check("R10", "read data", int'(rsp_rdata), int'(e.rd));
            busy_tb = 1'b0;
         end
         m_lat++;
      end
   end

   task automatic run_txn(input bit io, input bit wr, input bit wide, input bit attr,
                          input int ws, input bit iois_n, input int wait_rel,
                          input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [DW-1:0] card_pat);
      exp_t e;
      int   su, p;
      su = io ? 5 : 3;
      p  = (io ? 6 : 7) + ws;
      if (wait_rel > 0 && wait_rel + 2 > p) p = wait_rel + 2;
      e.lat     = su + p + 4;
      e.slen    = p;
      e.pin     = io ? (wr ? 4 : 3) : (wr ? 2 : 1);
      e.ce_pre  = io ? 2 : 3;
      e.doe     = wr ? e.lat : 0;
      e.ce2_low = wide && (!io || !iois_n);
      e.reg_low = io || attr;
      e.is_read = !wr;
      e.rd      = e.ce2_low ? card_pat : {8'h00, card_pat[7:0]};
      e.wd      = d;
      e.addr    = a;
      @(negedge clk);
      check("R11", "ready before request", int'(req_ready), 1);
      exp_q.push_back(e);
      req_io = io; req_write = wr; req_wide = wide; req_attr = attr;
      req_wait_cnt = WS_W'(ws); req_addr = a; req_wdata = d;
      card_rdata = card_pat; card_iois16_n = iois_n;
      card_wait_n = (wait_rel > 0) ? 1'b0 : 1'b1;
      req_valid = 1'b1;
      @(posedge clk);
      m_lat = 0; m_slen = 0; m_pin = 0; m_pre = 0; m_post = 0; m_doe = 0;
      m_seen = 1'b0; m_ce2 = 1'b0; m_reg = 1'b0; m_addr_ok = 1'b1; m_wd_ok = 1'b1;
      m_wait_rel = wait_rel;
      busy_tb = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait (busy_tb == 1'b0);
      @(negedge clk);
      card_wait_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle pin state
      check("R1", "ready", int'(req_ready), 1);
      check("R1", "done", int'(rsp_done), 0);
      check("R1", "strobes", int'({card_oe_n, card_we_n, card_iord_n, card_iowr_n}), 15);
      check("R1", "enables and reg", int'({card_ce1_n, card_ce2_n, card_reg_n}), 7);
      check("R1", "data enable", int'(card_data_oe), 0);

      // R4/R6/R10: memory read, 16-bit, no wait states
      run_txn(0, 0, 1, 0, 0, 1, 0, 26'h0001234, 16'h0000, 16'hBEEF);
      // R5/R8: memory write to register space
      run_txn(0, 1, 1, 1, 0, 1, 0, 26'h0000200, 16'hA55A, 16'h0000);
      // R6/R9/R10: memory byte read with 3 wait states
      run_txn(0, 0, 0, 0, 3, 1, 0, 26'h3FFFFFF, 16'h0000, 16'hC3D4);
      // R9: I/O read to a 16-bit port
      run_txn(1, 0, 1, 0, 0, 0, 0, 26'h00003F0, 16'h0000, 16'h1357);
      // R9/R10: I/O read narrowed by an 8-bit port
      run_txn(1, 0, 1, 0, 0, 1, 0, 26'h00003F2, 16'h0000, 16'h9ABC);
      // R5/R6: I/O write with 2 wait states
      run_txn(1, 1, 1, 0, 2, 0, 0, 26'h0000100, 16'h6789, 16'h0000);
      // R7: late WAIT release stretches the memory strobe
      run_txn(0, 0, 1, 0, 0, 1, 12, 26'h0000040, 16'h0000, 16'h4242);
      // R7: WAIT release lands on the same edge as count expiry
      run_txn(0, 0, 1, 0, 0, 1, 5, 26'h0000044, 16'h0000, 16'h5151);
      // R7: WAIT release one clock after count expiry
      run_txn(0, 0, 1, 0, 0, 1, 6, 26'h0000048, 16'h0000, 16'h6161);
      // R7: I/O strobe stretched by WAIT
      run_txn(1, 0, 1, 0, 0, 0, 10, 26'h0000300, 16'h0000, 16'h7E7E);

      // R11: requests offered while busy are ignored
      fork
         run_txn(0, 0, 1, 0, 0, 1, 0, 26'h0000080, 16'h0000, 16'h0F0F);
         begin
            repeat (3) @(negedge clk);
            check("R11", "ready while busy", int'(req_ready), 0);
            req_valid = 1'b1;
            req_io = 1'b1;
            repeat (7) @(negedge clk);
            req_valid = 1'b0;
         end
      join
      repeat (3) @(negedge clk);
      check("R11", "no extra access ce1", int'(card_ce1_n), 1);
      check("R11", "no extra access ready", int'(req_ready), 1);
      check("R11", "queue empty", exp_q.size(), 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule